// File: doc/BRIEF.md
# Shadow-Buffered Multi-Alignment PWM Timer

This block drives a group of pulse-width-modulated outputs from one shared timebase counter. A period value sets the counter's terminal count. Each channel compares the live count with its own duty value to decide its output level. In edge mode the counter ramps up from zero to the terminal count and then restarts. In center mode it climbs to the terminal count and falls back toward zero, so every channel's pulse sits symmetrically around the zero point of the count.

Software writes the block through a plain address/data/strobe port. Duty and period writes land in shadow copies. The working (active) copies take them over only at the boundary between two periods, so a pulse is never cut short or stretched part-way through. A control bit bypasses this buffering so that writes act at once. In edge mode each channel can be set left-aligned (pulse at the start of the period) or right-aligned (pulse at the end). A one-cycle pulse marks the last count of every period. When the global enable is low, the timebase idles at zero and the outputs stay low.

Top module: `pwm_timer_group`

## Requirements
- R1: In edge mode with active period P, the count runs 0,1,…,P and restarts at 0, so a period lasts P+1 cycles. `period_pulse_o` is high for one cycle per period, on the output cycle of the final count.
- R2: A left-aligned edge-mode channel with duty D (1 ≤ D ≤ P) is high for the first D cycles of each period and low for the rest.
- R3: A right-aligned edge-mode channel with duty D (1 ≤ D ≤ P) is low at the start of each period and high for its last D cycles.
- R4: In center mode the count runs 0 up to P, then P−1 down to 1, so a period lasts 2P cycles. A channel is high whenever the count is below D on either slope, which gives 2D−1 high cycles for 1 ≤ D ≤ P, centred on count zero.
- R5: A duty of 0 holds a channel low in every mode. A duty greater than P holds it high for the whole period.
- R6: With bypass clear, a duty write made during a period leaves that period unchanged. The new value governs the next period.
- R7: With bypass clear, a period write is also shadowed. It takes effect at the same period boundary as the duty values.
- R8: With bypass set, a duty write updates the active value in the next cycle. The output follows it one further cycle later, because outputs are registered from the previous cycle's count and duty.
- R9: While `en_i` is low, the counter is held at zero, all outputs and `period_pulse_o` are low, and active values continuously copy the shadow values. After re-enabling, the first period therefore uses the values written while idle.
- R10: Register map. Address 0 is control: bit 0 selects center mode, bit 1 sets bypass, and bit 2+i makes channel i right-aligned in edge mode. Control acts immediately. Address 1 is the period. Address 2+i is the duty of channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Global run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_o | output | N_CH | Registered PWM output per channel |
| period_pulse_o | output | 1 | One-cycle marker of the last count of each period |

## Verification
The bench builds the block with its default 8-bit counter and three channels. This lets one run hold a left-aligned, a right-aligned and a constant channel side by side, and lets every control bit fit in one write word. Periods of 8, 9 and 19 keep each period short. That brings into reach the full-period checks of exact high-cycle counts, pulse position at the first and last sample, center symmetry, and the exact cycle at which a bypassed write bends a pulse. Duties of 0, P+1 and 255 exercise the constant-level edges.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTER = 2'd2
  } align_e;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_PERIOD = 1;
  localparam int unsigned ADDR_DUTY0  = 2;

  localparam int unsigned CTRL_CENTER = 0;
  localparam int unsigned CTRL_BYPASS = 1;
  localparam int unsigned CTRL_RIGHT0 = 2;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             up_q, up_n;
  logic             last;

  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    last  = 1'b0;
    if (!center_i) begin
      up_n = 1'b1;
      if (cnt_q >= period_i) begin
        last  = 1'b1;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end else if (up_q) begin
      if (cnt_q >= period_i) begin
        if (period_i <= ONE) begin
          last  = 1'b1;
          cnt_n = '0;
        end else begin
          cnt_n = period_i - ONE;
          up_n  = 1'b0;
        end
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        last  = 1'b1;
        cnt_n = '0;
        up_n  = 1'b1;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
    if (!en_i) begin
      cnt_n = '0;
      up_n  = 1'b1;
      last  = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = last;

endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       load_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  output logic                       center_o,
  output logic                       bypass_o,
  output logic [N_CH-1:0]            right_o,
  output logic [CNT_W-1:0]           period_o,
  output logic [N_CH-1:0][CNT_W-1:0] duty_o
);

  localparam int unsigned CTRL_W = CTRL_RIGHT0 + N_CH;

  logic [CTRL_W-1:0] ctrl_q;
  logic              take;
  logic              hit_period;

  assign take       = !en_i || load_i;
  assign hit_period = wr_en_i && (int'(wr_addr_i) == ADDR_PERIOD);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && (int'(wr_addr_i) == ADDR_CTRL)) begin
      ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  assign center_o = ctrl_q[CTRL_CENTER];
  assign bypass_o = ctrl_q[CTRL_BYPASS];
  assign right_o  = ctrl_q[CTRL_W-1:CTRL_RIGHT0];

  // period: shadow plus active copy
  logic [CNT_W-1:0] per_sh_q, per_act_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      per_sh_q  <= '1;
      per_act_q <= '1;
    end else begin
      if (hit_period) per_sh_q <= wr_data_i;
      if (hit_period && bypass_o) per_act_q <= wr_data_i;
      else if (take)              per_act_q <= per_sh_q;
    end
  end

  assign period_o = per_act_q;

  // duty: one shadow/active pair per channel
  for (genvar g = 0; g < N_CH; g++) begin : g_duty
    logic [CNT_W-1:0] sh_q, act_q;
    logic             hit;

    assign hit = wr_en_i && (int'(wr_addr_i) == ADDR_DUTY0 + g);

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (hit) sh_q <= wr_data_i;
        if (hit && bypass_o) act_q <= wr_data_i;
        else if (take)       act_q <= sh_q;
      end
    end

    assign duty_o[g] = act_q;
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  align_e           align_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] tail_sum;
  logic             level;
  logic             pwm_q;

  assign tail_sum = {1'b0, cnt_i} + {1'b0, duty_i};

  always_comb begin
    unique case (align_i)
      ALIGN_RIGHT: level = tail_sum > {1'b0, period_i};
      default:     level = cnt_i < duty_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i && level;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_timer_group.sv
module pwm_timer_group
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [N_CH-1:0]   pwm_o,
  output logic              period_pulse_o
);

  logic                       center, bypass;
  logic [N_CH-1:0]            right;
  logic [CNT_W-1:0]           act_period;
  logic [N_CH-1:0][CNT_W-1:0] act_duty;
  logic [CNT_W-1:0]           cnt;
  logic                       last;
  logic                       load;
  logic                       pulse_q;

  assign load = en_i && last;

  pwm_regbank #(
    .CNT_W (CNT_W),
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .load_i   (load),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .center_o (center),
    .bypass_o (bypass),
    .right_o  (right),
    .period_o (act_period),
    .duty_o   (act_duty)
  );

  pwm_timebase #(
    .CNT_W(CNT_W)
  ) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .center_i(center),
    .period_i(act_period),
    .cnt_o   (cnt),
    .last_o  (last)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    align_e mode;
    assign mode = center   ? ALIGN_CENTER :
                  right[g] ? ALIGN_RIGHT  : ALIGN_LEFT;

    pwm_compare #(
      .CNT_W(CNT_W)
    ) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .align_i (mode),
      .cnt_i   (cnt),
      .period_i(act_period),
      .duty_i  (act_duty[g]),
      .pwm_o   (pwm_o[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= load;
  end

  assign period_pulse_o = pulse_q;

endmodule

// File: rtl/pwm_timer_group_sva.sv
module pwm_timer_group_sva #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned N_CH  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_i,
  input logic                       bypass,
  input logic                       last,
  input logic [CNT_W-1:0]           cnt,
  input logic [CNT_W-1:0]           act_period,
  input logic [N_CH-1:0][CNT_W-1:0] act_duty,
  input logic [N_CH-1:0]            pwm_o,
  input logic                       period_pulse_o
);

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_o == '0 && !period_pulse_o));

  a_r1_pulse_at_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_pulse_o |-> (cnt == '0));

  a_r7_period_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass && !last) |=> $stable(act_period));

  a_r6_duty_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass && !last) |=> $stable(act_duty));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    a_r5_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_duty[g] == '0) |=> !pwm_o[g]);

    a_r5_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cnt <= act_period && act_duty[g] > act_period) |=> pwm_o[g]);
  end

endmodule

bind pwm_timer_group pwm_timer_group_sva #(
  .CNT_W(CNT_W),
  .N_CH (N_CH)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .bypass        (bypass),
  .last          (last),
  .cnt           (cnt),
  .act_period    (act_period),
  .act_duty      (act_duty),
  .pwm_o         (pwm_o),
  .period_pulse_o(period_pulse_o)
);

// File: tb/pwm_timer_group_test.sv
module pwm_timer_group_test;

  localparam int unsigned CNT_W  = 8;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned MAXS   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [N_CH-1:0]   pwm;
  logic              pulse;

  int n_checks = 0;
  int n_fail   = 0;

  logic [N_CH-1:0] samp [MAXS];
  int              plen;

  always #4 clk = ~clk;

  pwm_timer_group #(
    .CNT_W (CNT_W),
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W)
  ) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .en_i          (en),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .pwm_o         (pwm),
    .period_pulse_o(pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // waits for a boundary pulse, then captures one full period of samples;
  // optionally drives a write at sample index wr_at
  task automatic run_period(input bit do_wr, input int wr_at, input int addr, input int data);
    int guard = 0;
    int idx = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!pulse && guard < 2000);
    plen = 0;
    if (!pulse) begin
      chk(1'b0, "timeout waiting for boundary", 0, 1);
      return;
    end
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < MAXS) samp[idx] = pwm;
      if (do_wr && idx == wr_at) begin
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = CNT_W'(data);
      end
      idx++;
      if (pulse || idx >= 2000) break;
    end
    wr_en = 1'b0;
    plen  = idx;
  endtask

  function automatic int hi(input int ch);
    int c = 0;
    for (int i = 0; i < plen && i < MAXS; i++) if (samp[i][ch]) c++;
    return c;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(pwm == '0, "R9 reset outputs low", int'(pwm), 0);
    chk(!pulse, "R9 reset no pulse", int'(pulse), 0);
  endtask

  task automatic t_edge();
    wr(1, 9); wr(2, 3); wr(3, 4); wr(4, 0);
    wr(0, 1 << 3);
    en = 1'b1;
    run_period(0, 0, 0, 0);
    chk(plen == 10, "R1 edge period length", plen, 10);
    chk(hi(0) == 3, "R2 left high count", hi(0), 3);
    chk(samp[0][0] && !samp[9][0], "R2 left pulse at start", int'(samp[0][0]), 1);
    chk(hi(1) == 4, "R3 right high count", hi(1), 4);
    chk(!samp[0][1] && samp[9][1], "R3 right pulse at end", int'(samp[9][1]), 1);
    chk(hi(2) == 0, "R5 zero duty low", hi(2), 0);
    chk(samp[6][1] && !samp[5][1], "R10 map ch1 right via ctrl bit 3", int'(samp[6][1]), 1);
  endtask

  task automatic t_full();
    wr(4, 10);
    run_period(0, 0, 0, 0);
    chk(hi(2) == 10, "R5 duty P+1 constant high", hi(2), 10);
    wr(4, 255);
    run_period(0, 0, 0, 0);
    chk(hi(2) == 10, "R5 duty 255 constant high", hi(2), 10);
  endtask

  task automatic t_period_shadow();
    run_period(1, 1, 1, 19);
    chk(plen == 10, "R7 period write deferred", plen, 10);
    run_period(0, 0, 0, 0);
    chk(plen == 20, "R7 new period applied", plen, 20);
  endtask

  task automatic t_duty_shadow();
    wr(2, 12);
    run_period(0, 0, 0, 0);
    chk(hi(0) == 12, "R6 setup duty 12", hi(0), 12);
    run_period(1, 4, 2, 2);
    chk(hi(0) == 12, "R6 mid-period write deferred", hi(0), 12);
    run_period(0, 0, 0, 0);
    chk(hi(0) == 2, "R6 new duty next period", hi(0), 2);
  endtask

  task automatic t_bypass();
    wr(0, (1 << 3) | 2);
    wr(2, 12);
    run_period(1, 4, 2, 2);
    chk(hi(0) == 6, "R8 R10 bypass write bends pulse", hi(0), 6);
  endtask

  task automatic t_center();
    wr(0, 1);
    wr(1, 8); wr(2, 3); wr(3, 9); wr(4, 0);
    run_period(0, 0, 0, 0);
    run_period(0, 0, 0, 0);
    chk(plen == 16, "R4 center period 2P", plen, 16);
    chk(hi(0) == 5, "R4 center high 2D-1", hi(0), 5);
    chk(samp[0][0] && samp[2][0] && !samp[3][0], "R4 rising side", int'(samp[2][0]), 1);
    chk(!samp[13][0] && samp[14][0] && samp[15][0], "R4 falling side", int'(samp[14][0]), 1);
    chk(hi(1) == 16, "R5 center duty above P", hi(1), 16);
    chk(hi(2) == 0, "R5 center duty zero", hi(2), 0);
  endtask

  task automatic t_disable();
    @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(pwm == '0, "R9 outputs low while off", int'(pwm), 0);
        chk(!pulse, "R9 no pulse while off", int'(pulse), 0);
      end
    end
    wr(2, 6);
    @(negedge clk);
    en = 1'b1;
    run_period(0, 0, 0, 0);
    chk(hi(0) == 11, "R9 idle write used after enable", hi(0), 11);
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_edge();
    t_full();
    t_period_shadow();
    t_duty_shadow();
    t_bypass();
    t_center();
    t_disable();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule